// File: doc/BRIEF.md
# IPv4 Longest-Prefix Route Stage

This block is one match-action stage of a packet pipeline. It routes IPv4 traffic. Each beat carries parsed header fields: destination address, TTL and header checksum. It also carries the current next-hop and egress-port metadata, plus a flag that says whether an IPv4 header is present. When that flag is set, the destination address is looked up in a small programmable prefix table, and the longest matching prefix selects an action. A next-hop action rewrites the next-hop and egress-port metadata, decrements the TTL and patches the checksum. A drop action, or a lookup that matches nothing, marks the packet as dropped and leaves its header as it was. Beats without an IPv4 header pass through untouched, so that a separate path can handle them.

Beats enter and leave on valid/ready handshakes. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high, and delivered on an edge where `out_valid` and `out_ready` are both high. `in_ready` equals `!out_valid || out_ready`, so a stalled output freezes the whole two-register pipe. While `out_ready` is low the held result does not change. Table entries are loaded through a plain write port. A write takes effect one edge later.

Top module: `lpm_route_stage`

## Requirements
- R1: The key is the 32-bit destination address. An entry matches when its first L address bits equal its prefix; L=0 matches every address and L>32 is treated as 32. Among matching valid entries the longest effective L wins, and entries whose valid bit is 0 never match.
- R2: When matching entries share the longest length, the one with the lowest index wins.
- R3: An IPv4 beat that matches no entry leaves with `out_drop`=1 and with its TTL, checksum, next-hop and port unchanged.
- R4: Action code 0 (next hop) sets `out_nhop` and `out_port` to the entry's values, with `out_drop`=0.
- R5: Action code 0 sets `out_ttl` to the input TTL minus one, modulo 256.
- R6: With action code 0, `out_csum` is ~(~C + ~M + M') in one's-complement arithmetic. C is the input checksum, M is {old TTL, 8'h00} and M' is {new TTL, 8'h00}. It therefore equals the full header checksum recomputed with the new TTL.
- R7: Action code 1 (drop) sets `out_drop`=1 and leaves TTL, checksum, next-hop and port unchanged.
- R8: A beat with `in_ipv4_valid`=0 leaves with all fields equal to its input fields and `out_drop`=0, whatever the table holds.
- R9: `in_ready` = `!out_valid || out_ready`. With `out_ready` high, a beat accepted on one edge shows on the outputs after the next edge, and one beat can be accepted every cycle. While `out_valid`=1 and `out_ready`=0, all outputs hold steady. Beats leave in the order they were accepted. After reset `out_valid`=0.
- R10: A write with `wr_en`=1 on an edge stores the entry at `wr_idx`. A beat accepted on that same edge still sees the old entry, and a beat accepted on any later edge sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_ipv4_valid | input | 1 | IPv4 header present |
| in_dst_addr | input | 32 | IPv4 destination address |
| in_ttl | input | 8 | IPv4 TTL |
| in_csum | input | 16 | IPv4 header checksum |
| in_nhop | input | 32 | Incoming next-hop metadata |
| in_port | input | PORT_W | Incoming egress-port metadata |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_ipv4_valid | output | 1 | IPv4 header present |
| out_dst_addr | output | 32 | Destination address (unchanged) |
| out_ttl | output | 8 | Resulting TTL |
| out_csum | output | 16 | Resulting checksum |
| out_nhop | output | 32 | Resulting next-hop metadata |
| out_port | output | PORT_W | Resulting egress-port metadata |
| out_drop | output | 1 | Beat is to be dropped |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Entry valid bit |
| wr_prefix | input | 32 | Entry prefix |
| wr_len | input | 6 | Entry prefix length |
| wr_act | input | 1 | Entry action: 0 next hop, 1 drop |
| wr_nhop | input | 32 | Entry next-hop address |
| wr_port | input | PORT_W | Entry egress port |

## Verification
Three cases are hard to reach from the ports. The first is an equal-length tie between two matching entries. The second is a write landing on the same edge as a lookup of that very entry. The third is a stall arriving while both pipe registers hold beats. Random addresses would almost never produce the first two. Directed steps therefore load duplicate prefixes at different indices, and drive a write together with a beat aimed at the rewritten prefix, then repeat that beat one cycle later. The random phase draws most destinations from the subnet the table prefixes live in, and toggles `out_ready` often, so overlapping stalls and table rewrites occur many times.

// File: rtl/lpm_route_pkg.sv
package lpm_route_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;
  localparam int TTL_W  = 8;
  localparam int CSUM_W = 16;

  typedef enum logic {ACT_NHOP = 1'b0, ACT_DROP = 1'b1} act_e;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] len);
    return (len > LEN_W'(ADDR_W)) ? LEN_W'(ADDR_W) : len;
  endfunction

  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] l;
    l = eff_len(len);
    if (l == '0) return '0;
    return ~({ADDR_W{1'b1}} >> l);
  endfunction

  function automatic logic [CSUM_W-1:0] csum_patch(input logic [CSUM_W-1:0] c,
                                                   input logic [TTL_W-1:0] t_old,
                                                   input logic [TTL_W-1:0] t_new);
    logic [CSUM_W+1:0] s;
    logic [CSUM_W:0]   f1;
    logic [CSUM_W:0]   f2;
    s  = {2'b00, ~c} + {2'b00, ~{t_old, 8'h00}} + {2'b00, t_new, 8'h00};
    f1 = {1'b0, s[CSUM_W-1:0]} + {{(CSUM_W-1){1'b0}}, s[CSUM_W+1:CSUM_W]};
    f2 = {1'b0, f1[CSUM_W-1:0]} + {{CSUM_W{1'b0}}, f1[CSUM_W]};
    return ~f2[CSUM_W-1:0];
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_route_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] wr_nhop,
  input  logic [PORT_W-1:0] wr_port,
  output logic              t_valid  [N_ENTRIES],
  output logic [ADDR_W-1:0] t_prefix [N_ENTRIES],
  output logic [LEN_W-1:0]  t_len    [N_ENTRIES],
  output logic              t_act    [N_ENTRIES],
  output logic [ADDR_W-1:0] t_nhop   [N_ENTRIES],
  output logic [PORT_W-1:0] t_port   [N_ENTRIES]
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_valid[i]  <= 1'b0;
        t_prefix[i] <= '0;
        t_len[i]    <= '0;
        t_act[i]    <= 1'b0;
        t_nhop[i]   <= '0;
        t_port[i]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        t_valid[i]  <= wr_valid;
        t_prefix[i] <= wr_prefix;
        t_len[i]    <= wr_len;
        t_act[i]    <= wr_act;
        t_nhop[i]   <= wr_nhop;
        t_port[i]   <= wr_port;
      end
    end

    // R10: a write is visible on the following cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=>
        (t_prefix[i] == $past(wr_prefix) && t_valid[i] == $past(wr_valid)));
  end
endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_route_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] key,
  input  logic              t_valid  [N_ENTRIES],
  input  logic [ADDR_W-1:0] t_prefix [N_ENTRIES],
  input  logic [LEN_W-1:0]  t_len    [N_ENTRIES],
  output logic              found,
  output logic [IDX_W-1:0]  sel
);
  logic [N_ENTRIES-1:0] hit;
  logic [LEN_W-1:0]     elen [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign elen[i] = eff_len(t_len[i]);
    assign hit[i]  = t_valid[i] &&
                     (((key ^ t_prefix[i]) & len_mask(t_len[i])) == '0);
  end

  // ascending scan, strict compare: the lower index keeps a tie
  always_comb begin
    logic [LEN_W-1:0] best;
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit[i] && (!found || elen[i] > best)) begin
        found = 1'b1;
        sel   = IDX_W'(i);
        best  = elen[i];
      end
    end
  end

  p_sel_is_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> hit[sel]);
  p_miss_means_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (hit == '0));
  for (genvar j = 0; j < N_ENTRIES; j++) begin : g_chk
    p_no_longer_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (found && hit[j]) |-> (elen[j] <= elen[sel]));
    p_tie_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (found && hit[j] && elen[j] == elen[sel]) |-> (IDX_W'(j) >= sel));
  end
endmodule

// File: rtl/lpm_action.sv
module lpm_action
  import lpm_route_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              ipv4,
  input  logic              found,
  input  logic              act,
  input  logic [TTL_W-1:0]  ttl,
  input  logic [CSUM_W-1:0] csum,
  input  logic [ADDR_W-1:0] nhop,
  input  logic [PORT_W-1:0] port,
  input  logic [ADDR_W-1:0] e_nhop,
  input  logic [PORT_W-1:0] e_port,
  output logic [TTL_W-1:0]  r_ttl,
  output logic [CSUM_W-1:0] r_csum,
  output logic [ADDR_W-1:0] r_nhop,
  output logic [PORT_W-1:0] r_port,
  output logic              r_drop
);
  logic [TTL_W-1:0] ttl_dec;
  assign ttl_dec = ttl - TTL_W'(1);

  always_comb begin
    r_ttl  = ttl;
    r_csum = csum;
    r_nhop = nhop;
    r_port = port;
    r_drop = 1'b0;
    if (ipv4) begin
      if (!found || act_e'(act) == ACT_DROP) begin
        r_drop = 1'b1;
      end else begin
        r_ttl  = ttl_dec;
        r_csum = csum_patch(csum, ttl, ttl_dec);
        r_nhop = e_nhop;
        r_port = e_port;
      end
    end
  end
endmodule

// File: rtl/lpm_route_stage.sv
module lpm_route_stage
  import lpm_route_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ipv4_valid,
  input  logic [31:0]       in_dst_addr,
  input  logic [7:0]        in_ttl,
  input  logic [15:0]       in_csum,
  input  logic [31:0]       in_nhop,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ipv4_valid,
  output logic [31:0]       out_dst_addr,
  output logic [7:0]        out_ttl,
  output logic [15:0]       out_csum,
  output logic [31:0]       out_nhop,
  output logic [PORT_W-1:0] out_port,
  output logic              out_drop,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [31:0]       wr_prefix,
  input  logic [5:0]        wr_len,
  input  logic              wr_act,
  input  logic [31:0]       wr_nhop,
  input  logic [PORT_W-1:0] wr_port
);
  logic              t_valid  [N_ENTRIES];
  logic [ADDR_W-1:0] t_prefix [N_ENTRIES];
  logic [LEN_W-1:0]  t_len    [N_ENTRIES];
  logic              t_act    [N_ENTRIES];
  logic [ADDR_W-1:0] t_nhop   [N_ENTRIES];
  logic [PORT_W-1:0] t_port   [N_ENTRIES];

  lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_valid, .wr_prefix, .wr_len,
    .wr_act, .wr_nhop, .wr_port,
    .t_valid, .t_prefix, .t_len, .t_act, .t_nhop, .t_port
  );

  logic             m_found;
  logic [IDX_W-1:0] m_sel;

  lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .clk, .rst_n, .key(in_dst_addr),
    .t_valid, .t_prefix, .t_len,
    .found(m_found), .sel(m_sel)
  );

  // one enable for the whole pipe: it stalls as a unit
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 1: header plus the selected entry's action parameters
  logic              s1_v, s1_ip, s1_found, s1_act;
  logic [ADDR_W-1:0] s1_dst, s1_nhop, s1_enhop;
  logic [TTL_W-1:0]  s1_ttl;
  logic [CSUM_W-1:0] s1_csum;
  logic [PORT_W-1:0] s1_port, s1_eport;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_ip <= 1'b0; s1_found <= 1'b0; s1_act <= 1'b0;
      s1_dst <= '0; s1_nhop <= '0; s1_enhop <= '0; s1_ttl <= '0;
      s1_csum <= '0; s1_port <= '0; s1_eport <= '0;
    end else if (adv) begin
      s1_v     <= in_valid;
      s1_ip    <= in_ipv4_valid;
      s1_found <= m_found && in_ipv4_valid;
      s1_act   <= t_act[m_sel];
      s1_dst   <= in_dst_addr;
      s1_nhop  <= in_nhop;
      s1_enhop <= t_nhop[m_sel];
      s1_ttl   <= in_ttl;
      s1_csum  <= in_csum;
      s1_port  <= in_port;
      s1_eport <= t_port[m_sel];
    end
  end

  logic [TTL_W-1:0]  a_ttl;
  logic [CSUM_W-1:0] a_csum;
  logic [ADDR_W-1:0] a_nhop;
  logic [PORT_W-1:0] a_port;
  logic              a_drop;

  lpm_action #(.PORT_W(PORT_W)) u_action (
    .ipv4(s1_ip), .found(s1_found), .act(s1_act), .ttl(s1_ttl),
    .csum(s1_csum), .nhop(s1_nhop), .port(s1_port),
    .e_nhop(s1_enhop), .e_port(s1_eport),
    .r_ttl(a_ttl), .r_csum(a_csum), .r_nhop(a_nhop), .r_port(a_port),
    .r_drop(a_drop)
  );

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_ipv4_valid <= 1'b0; out_dst_addr <= '0;
      out_ttl <= '0; out_csum <= '0; out_nhop <= '0; out_port <= '0;
      out_drop <= 1'b0;
    end else if (adv) begin
      out_valid      <= s1_v;
      out_ipv4_valid <= s1_ip;
      out_dst_addr   <= s1_dst;
      out_ttl        <= a_ttl;
      out_csum       <= a_csum;
      out_nhop       <= a_nhop;
      out_port       <= a_port;
      out_drop       <= a_drop;
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_ttl) && $stable(out_csum) &&
       $stable(out_nhop) && $stable(out_port) && $stable(out_drop) &&
       $stable(out_dst_addr)));
  p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_bypass_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ipv4_valid) |-> !out_drop);
  p_drop_keeps_ttl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v && s1_ip && s1_found && s1_act) |=>
      (out_drop && out_ttl == $past(s1_ttl)));
endmodule

// File: tb/tb_lpm_route_stage.sv
module tb_lpm_route_stage;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_ipv4_valid, out_valid, out_ready;
  logic out_ipv4_valid, out_drop, wr_en, wr_valid, wr_act;
  logic [31:0] in_dst_addr, in_nhop, out_dst_addr, out_nhop, wr_prefix, wr_nhop;
  logic [7:0]  in_ttl, out_ttl;
  logic [15:0] in_csum, out_csum;
  logic [PW-1:0] in_port, out_port, wr_port;
  logic [IW-1:0] wr_idx;
  logic [5:0] wr_len;

  lpm_route_stage #(.N_ENTRIES(N), .PORT_W(PW)) dut (.*);

  typedef struct {
    logic ip; logic [31:0] dst; logic [7:0] ttl; logic [15:0] csum;
    logic [31:0] nhop; logic [PW-1:0] port; logic drop; string tag;
  } exp_t;

  exp_t exp_q[$];
  int errors = 0, checks = 0;
  bit done = 0;
  string tag_ovr = "";

  logic sh_v [N]; logic [31:0] sh_p [N]; logic [5:0] sh_l [N];
  logic sh_a [N]; logic [31:0] sh_n [N]; logic [PW-1:0] sh_t [N];

  function automatic logic [15:0] fold_csum(input logic [31:0] s);
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return ~s[15:0];
  endfunction

  function automatic exp_t model(input logic ip, input logic [31:0] dst,
      input logic [7:0] ttl, input logic [15:0] cs, input logic [31:0] nh,
      input logic [PW-1:0] pt, input logic [31:0] rest);
    exp_t e; int best; int bl;
    e.ip = ip; e.dst = dst; e.ttl = ttl; e.csum = cs; e.nhop = nh;
    e.port = pt; e.drop = 0; e.tag = "R8";
    if (ip) begin
      best = -1; bl = 0;
      for (int i = 0; i < N; i++) begin
        int l; logic [31:0] m;
        l = (sh_l[i] > 32) ? 32 : int'(sh_l[i]);
        m = (l == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> l);
        if (sh_v[i] && ((dst & m) == (sh_p[i] & m)) && (best < 0 || l > bl)) begin
          best = i; bl = l;
        end
      end
      if (best < 0) begin e.drop = 1; e.tag = "R3"; end
      else if (sh_a[best]) begin e.drop = 1; e.tag = "R7"; end
      else begin
        e.nhop = sh_n[best]; e.port = sh_t[best]; e.ttl = ttl - 8'd1;
        e.csum = fold_csum(rest + {16'h0, ttl - 8'd1, 8'h00});
        e.tag = "R4/R5/R6";
      end
    end
    if (tag_ovr != "") e.tag = tag_ovr;
    return e;
  endfunction

  logic [31:0] cur_rest;
  logic prev_stall = 0;
  exp_t snap;

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", req, what); end
  endtask

  // called at a negedge with inputs driven; advances one cycle
  task automatic cycle();
    exp_t e, g;
    #1;
    g.ip = out_ipv4_valid; g.dst = out_dst_addr; g.ttl = out_ttl; g.csum = out_csum;
    g.nhop = out_nhop; g.port = out_port; g.drop = out_drop;
    if (prev_stall)
      chk(out_valid && g.ttl == snap.ttl && g.csum == snap.csum && g.nhop == snap.nhop &&
          g.port == snap.port && g.drop == snap.drop && g.dst == snap.dst, "R9",
          $sformatf("held output changed: ttl %h/%h nhop %h/%h", g.ttl, snap.ttl, g.nhop, snap.nhop));
    prev_stall = out_valid && !out_ready;
    snap = g;
    chk(in_ready == (!out_valid || out_ready), "R9",
        $sformatf("in_ready=%b expected %b", in_ready, !out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R9", "output with no beat pending: actual 1 expected 0");
      else begin
        bit cok;
        e = exp_q.pop_front();
        cok = (g.csum == e.csum) ||
              ((g.csum == 16'h0 || g.csum == 16'hFFFF) && (e.csum == 16'h0 || e.csum == 16'hFFFF));
        chk(g.ip == e.ip && g.dst == e.dst && g.ttl == e.ttl && cok && g.nhop == e.nhop &&
            g.port == e.port && g.drop == e.drop, e.tag,
            $sformatf("actual ttl=%h cs=%h nh=%h pt=%h drop=%b expected ttl=%h cs=%h nh=%h pt=%h drop=%b",
                      g.ttl, g.csum, g.nhop, g.port, g.drop, e.ttl, e.csum, e.nhop, e.port, e.drop));
      end
    end
    if (in_valid && in_ready)
      exp_q.push_back(model(in_ipv4_valid, in_dst_addr, in_ttl, in_csum, in_nhop, in_port, cur_rest));
    if (wr_en) begin
      sh_v[wr_idx] = wr_valid; sh_p[wr_idx] = wr_prefix; sh_l[wr_idx] = wr_len;
      sh_a[wr_idx] = wr_act; sh_n[wr_idx] = wr_nhop; sh_t[wr_idx] = wr_port;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pkt(input logic ip, input logic [31:0] dst, input logic [7:0] ttl);
    cur_rest = {16'h0, 16'($urandom)};
    in_valid = 1; in_ipv4_valid = ip; in_dst_addr = dst; in_ttl = ttl;
    in_csum = fold_csum(cur_rest + {16'h0, ttl, 8'h00});
    in_nhop = $urandom; in_port = PW'($urandom);
  endtask

  task automatic set_wr(input int idx, input logic v, input logic [31:0] p, input logic [5:0] l,
                        input logic a, input logic [31:0] nh, input logic [PW-1:0] pt);
    wr_en = 1; wr_idx = IW'(idx); wr_valid = v; wr_prefix = p; wr_len = l;
    wr_act = a; wr_nhop = nh; wr_port = pt;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      sh_v[i] = 0; sh_p[i] = 0; sh_l[i] = 0; sh_a[i] = 0; sh_n[i] = 0; sh_t[i] = 0;
    end
    rst_n = 0; in_valid = 0; in_ipv4_valid = 0; in_dst_addr = 0; in_ttl = 0;
    in_csum = 0; in_nhop = 0; in_port = 0; out_ready = 1; cur_rest = 0;
    wr_en = 0; wr_idx = 0; wr_valid = 0; wr_prefix = 0; wr_len = 0;
    wr_act = 0; wr_nhop = 0; wr_port = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0 && in_ready == 1, "R9",
        $sformatf("reset state valid=%b ready=%b expected 0 1", out_valid, in_ready));
    @(negedge clk);

    // empty table: IPv4 misses (R3), bypass untouched (R8)
    set_pkt(1, 32'h0A01_0203, 8'd40); cycle();
    set_pkt(0, 32'h0A01_0203, 8'd40); cycle();
    in_valid = 0; cycle(); cycle();

    // latency R9: accept on one edge, visible after the next
    set_pkt(0, 32'h1, 8'd9); #1;
    cycle(); in_valid = 0; #1;
    chk(out_valid == 0, "R9", $sformatf("early output actual %b expected 0", out_valid));
    cycle(); #1;
    chk(out_valid == 1, "R9", $sformatf("latency output actual %b expected 1", out_valid));
    cycle();

    // tie R2: equal length duplicates at idx 5 and 2, then lengths R1
    set_wr(5, 1, 32'h0A0B_0000, 6'd16, 0, 32'h5555_5555, 4'd5); cycle();
    set_wr(2, 1, 32'h0A0B_0000, 6'd16, 0, 32'h2222_2222, 4'd2); cycle();
    set_wr(6, 1, 32'h0A0B_0C00, 6'd40, 0, 32'h6666_6666, 4'd6); cycle();
    set_wr(1, 1, 32'h0000_0000, 6'd0, 1, 32'h1111_1111, 4'd1); cycle();
    wr_en = 0;
    tag_ovr = "R2"; set_pkt(1, 32'h0A0B_FFFF, 8'd1); cycle();
    tag_ovr = "R1"; set_pkt(1, 32'h0A0B_0C00, 8'd0); cycle();
    set_pkt(1, 32'hC000_0001, 8'd7); cycle();
    // R10: write and lookup on the same edge, then repeated
    tag_ovr = "R10";
    set_pkt(1, 32'h0A0B_1234, 8'd20);
    set_wr(2, 1, 32'h0A0B_1234, 6'd32, 0, 32'hABCD_0000, 4'd9); cycle();
    wr_en = 0; cycle();
    set_wr(2, 0, 32'h0A0B_1234, 6'd32, 0, 32'h0, 4'd0); set_pkt(1, 32'h0A0B_1234, 8'd20); cycle();
    wr_en = 0; cycle();
    in_valid = 0; tag_ovr = "";
    cycle(); cycle();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      out_ready = ($urandom % 4) != 0;
      if ($urandom % 3 != 0) begin
        logic [31:0] d;
        d = ($urandom % 4 != 0) ? (32'h0A00_0000 | ($urandom & 32'h00FF_FFFF)) : $urandom;
        set_pkt(($urandom % 5) != 0, d, 8'($urandom));
      end else in_valid = 0;
      if ($urandom % 10 == 0)
        set_wr(int'($urandom % N), ($urandom % 6) != 0,
               32'h0A00_0000 | ($urandom & 32'h00FF_FFFF), 6'($urandom % 36),
               ($urandom % 4) == 0, $urandom, PW'($urandom));
      else wr_en = 0;
      cycle();
    end

    in_valid = 0; wr_en = 0; out_ready = 1;
    repeat (4) cycle();
    chk(exp_q.size() == 0, "R9", $sformatf("beats lost: actual %0d pending expected 0", exp_q.size()));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule